// File: doc/BRIEF.md
# Streaming Kernel Wrapper with Two-Sided Handshake

This block places a fixed-latency arithmetic kernel between two flow-controlled streams. On the input side the block raises a request line whenever it has room. Upstream presents a word together with an available flag, and a word moves in only on an edge where both lines are high. On the output side the block raises its own available flag while a result is waiting. It holds that result, unchanged, until downstream signals with an acknowledge that it has taken it.

The kernel multiplies each word by a constant and adds a second constant, spread over a parameterised number of pipeline stages. A small result buffer behind the kernel catches words that are still in flight when downstream stalls. A credit counter covers both the pipeline and that buffer, and withdraws the input request before anything could be lost. Reset is asynchronous and active low, must be held for at least one clock cycle, and is released synchronously to the clock.

Top module: `strm_kernel_wrap`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_req` is 1 and `out_avail` is 0.
- R2: A word is captured on a rising edge only when `in_avail` and `in_req` are both 1 before that edge; the captured value is `in_data` as it stood then.
- R3: The number of words accepted but not yet acknowledged never exceeds BUF_DEPTH = STAGES + 2; once that many are outstanding, `in_req` is 0.
- R4: Once `out_avail` is 1, it stays 1 and `out_data` stays unchanged on every following edge until an edge where `out_ack` is 1.
- R5: Each result equals (x * SCALE + OFFSET) modulo 2^DATA_W, where x is the accepted input (defaults DATA_W = 16, SCALE = 3, OFFSET = 5).
- R6: Results leave in acceptance order, each exactly once, under any pattern of `in_avail` and `out_ack`. `out_avail` is never 1 while no accepted word is still unacknowledged.
- R7: With `in_avail` and `out_ack` held at 1 continuously, `in_req` stays 1 and one word is accepted on every edge.
- R8: `in_avail` asserted while `in_req` is 0 is ignored: no extra result ever appears at the output.
- R9: With the block empty, `out_avail` first becomes 1 on the STAGES-th rising edge after the edge that captured the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_avail | input | 1 | Upstream has a valid word on `in_data` |
| in_data | input | DATA_W | Input word |
| in_req | output | 1 | Block can accept a word this cycle |
| out_ack | input | 1 | Downstream has taken the current result |
| out_data | output | DATA_W | Result at the head of the buffer |
| out_avail | output | 1 | `out_data` holds a valid result |

## Verification
The hardest state to reach is a completely full block that is being drained and refilled on the same edge. In that state the credit count must stay flat while pipeline words, buffered words and the word at the head all line up in order. The bench gets there by sweeping every non-empty four-cycle pattern of input availability against every non-empty four-cycle pattern of acknowledge. This produces stalls, bubbles and simultaneous accept-and-pop edges at every phase. Directed runs add a fully backpressured fill with offers made while the request is low, a single-word latency probe, and a sustained full-rate stream.

// File: rtl/strm_pkg.sv
package strm_pkg;

  // Pointer width for a buffer of the given depth; never below one bit.
  function automatic int unsigned ptr_w(input int unsigned depth);
    int unsigned w;
    w = $clog2(depth);
    return (w < 1) ? 1 : w;
  endfunction

  // Width of a counter that must reach the value 'limit' inclusive.
  function automatic int unsigned cnt_w(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/kern_pipe.sv
module kern_pipe #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAGES = 3,
  parameter int unsigned SCALE  = 3,
  parameter int unsigned OFFSET = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_dat,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_dat
);

  localparam logic [DATA_W-1:0] SCALE_V = DATA_W'(SCALE);
  localparam logic [DATA_W-1:0] OFS_V   = DATA_W'(OFFSET);

  logic              vld_q [STAGES];
  logic [DATA_W-1:0] dat_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic              vld_d;
    logic [DATA_W-1:0] dat_d;

    if (s == 0) begin : g_head
      // First stage: scale; with a single stage the offset is folded in too.
      always_comb begin
        vld_d = in_vld;
        dat_d = in_dat * SCALE_V;
        if (STAGES == 1) dat_d = dat_d + OFS_V;
      end
    end else if (s == 1) begin : g_add
      always_comb begin
        vld_d = vld_q[0];
        dat_d = dat_q[0] + OFS_V;
      end
    end else begin : g_dly
      always_comb begin
        vld_d = vld_q[s-1];
        dat_d = dat_q[s-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[s] <= 1'b0;
      else        vld_q[s] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (vld_d) dat_q[s] <= dat_d;
    end
  end

  assign out_vld = vld_q[STAGES-1];
  assign out_dat = dat_q[STAGES-1];

endmodule

// File: rtl/res_fifo.sv
module res_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_dat,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_dat,
  output logic              empty
);

  localparam int unsigned PW = strm_pkg::ptr_w(DEPTH);
  localparam int unsigned CW = strm_pkg::cnt_w(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_en) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (rd_en) rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_dat;
  end

  assign rd_dat = mem[rp_q];
  assign empty  = (cnt_q == '0);

  // R3: a result from the pipeline never lands on a full buffer.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < CW'(DEPTH)) || rd_en);

  // R6: nothing is popped from an empty buffer.
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> cnt_q != '0);

endmodule

// File: rtl/credit_ctr.sv
module credit_ctr #(
  parameter int unsigned LIMIT = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                take,
  input  logic                                give,
  output logic                                room,
  output logic [strm_pkg::cnt_w(LIMIT)-1:0]   used
);

  localparam int unsigned CW = strm_pkg::cnt_w(LIMIT);

  logic [CW-1:0] used_q, used_d;
  logic          upd;

  always_comb begin
    upd    = take ^ give;
    used_d = take ? used_q + 1'b1 : used_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   used_q <= '0;
    else if (upd) used_q <= used_d;
  end

  assign room = (used_q < CW'(LIMIT));
  assign used = used_q;

  // R3: outstanding words stay within the limit.
  p_credit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CW'(LIMIT));

  // R6: a credit is only returned while one is outstanding.
  p_credit_give_r6: assert property (@(posedge clk) disable iff (!rst_n)
    give |-> used_q != '0);

endmodule

// File: rtl/strm_kernel_wrap.sv
module strm_kernel_wrap #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned STAGES = 3,
  parameter int unsigned SCALE  = 3,
  parameter int unsigned OFFSET = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_avail,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data,
  output logic              out_avail
);

  localparam int unsigned BUF_DEPTH = STAGES + 2;
  localparam int unsigned CW        = strm_pkg::cnt_w(BUF_DEPTH);

  logic              accept, pop;
  logic              room;
  logic [CW-1:0]     used;
  logic              pipe_vld;
  logic [DATA_W-1:0] pipe_dat;
  logic              buf_empty;

  assign accept    = in_avail & room;
  assign out_avail = ~buf_empty;
  assign pop       = out_avail & out_ack;
  assign in_req    = room;

  credit_ctr #(.LIMIT(BUF_DEPTH)) u_credit (
    .clk  (clk),
    .rst_n(rst_n),
    .take (accept),
    .give (pop),
    .room (room),
    .used (used)
  );

  kern_pipe #(
    .DATA_W(DATA_W), .STAGES(STAGES), .SCALE(SCALE), .OFFSET(OFFSET)
  ) u_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (accept),
    .in_dat (in_data),
    .out_vld(pipe_vld),
    .out_dat(pipe_dat)
  );

  res_fifo #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (pipe_vld),
    .wr_dat(pipe_dat),
    .rd_en (pop),
    .rd_dat(out_data),
    .empty (buf_empty)
  );

  // R4: a waiting result is held until acknowledged.
  p_hold_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_avail && !out_ack |=> out_avail);
  p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_avail && !out_ack |=> $stable(out_data));

  // R6: a visible result always corresponds to an outstanding credit.
  p_avail_credit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_avail |-> used != '0);

  // R2: a capture always leaves at least one credit outstanding.
  p_accept_counts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> used != '0);

endmodule

// File: tb/strm_kernel_wrap_tb.sv
module strm_kernel_wrap_tb;

  localparam int unsigned DW   = 16;
  localparam int unsigned STG  = 3;
  localparam int unsigned SCL  = 3;
  localparam int unsigned OFS  = 5;
  localparam int unsigned BUFD = STG + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_avail = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_req;
  logic          out_ack = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_avail;

  always #2.5 clk = ~clk;

  strm_kernel_wrap #(.DATA_W(DW), .STAGES(STG), .SCALE(SCL), .OFFSET(OFS)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_avail(in_avail), .in_data(in_data),
    .in_req(in_req), .out_ack(out_ack), .out_data(out_data), .out_avail(out_avail)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] q [256];
  int q_head = 0;
  int q_tail = 0;
  int last_acc = 0;
  int last_pop = 0;
  logic          hold_pend = 1'b0;
  logic [DW-1:0] hold_val  = '0;

  function automatic logic [DW-1:0] model(input logic [DW-1:0] x);
    return DW'(32'(x) * SCL + OFS);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, sample just after, edge follows.
  task automatic step(input bit av, input logic [DW-1:0] d, input bit ak);
    @(negedge clk);
    in_avail = av;
    in_data  = d;
    out_ack  = ak;
    #1;
    if (hold_pend) begin
      chk(out_avail == 1'b1, "R4 avail held", int'(out_avail), 1);
      chk(out_data == hold_val, "R4 data held", int'(out_data), int'(hold_val));
    end
    last_acc = 0;
    last_pop = 0;
    if (av && in_req) begin
      q[q_tail % 256] = model(d);
      q_tail++;
      last_acc = 1;
    end
    if (out_avail && ak) begin
      if (q_head == q_tail) begin
        chk(1'b0, "R6 duplicate or spurious result", int'(out_data), -1);
      end else begin
        chk(out_data == q[q_head % 256], "R5 R6 result value and order",
            int'(out_data), int'(q[q_head % 256]));
        q_head++;
      end
      last_pop = 1;
    end
    hold_pend = out_avail && !ak;
    hold_val  = out_data;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && (q_head != q_tail || out_avail); i++) step(1'b0, '0, 1'b1);
    chk(q_head == q_tail, "R6 all results delivered", q_tail - q_head, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(in_req == 1'b1, "R1 in_req during reset", int'(in_req), 1);
    chk(out_avail == 1'b0, "R1 out_avail during reset", int'(out_avail), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_req == 1'b1, "R1 in_req after reset", int'(in_req), 1);
    chk(out_avail == 1'b0, "R1 out_avail after reset", int'(out_avail), 0);

    // R9: latency of a single word through an empty block
    begin
      int n;
      step(1'b1, 16'd1234, 1'b0);
      chk(last_acc == 1, "R2 single capture", last_acc, 1);
      n = 0;
      while (!out_avail && n < 20) begin
        step(1'b0, '0, 1'b0);
        n++;
      end
      chk(n == STG + 1, "R9 first-result latency", n, STG + 1);
      drain();
    end

    // R3 + R8: fill under full backpressure, offers while request is low
    begin
      int acc;
      acc = 0;
      for (int i = 0; i < 12; i++) begin
        step(1'b1, DW'(16'hFFF0 + i), 1'b0);
        acc += last_acc;
      end
      chk(acc == BUFD, "R3 accepted under backpressure", acc, BUFD);
      chk(in_req == 1'b0, "R3 in_req low when full", int'(in_req), 0);
      for (int i = 0; i < 5; i++) step(1'b1, DW'(16'h0AA0 + i), 1'b0);
      chk(in_req == 1'b0, "R8 request stays low", int'(in_req), 0);
      drain();
      for (int i = 0; i < STG + 3; i++) step(1'b0, '0, 1'b1);
      chk(out_avail == 1'b0, "R8 no extra result after drain", int'(out_avail), 0);
    end

    // R7: sustained full rate
    begin
      int lows, acc;
      lows = 0;
      acc  = 0;
      for (int i = 0; i < 30; i++) begin
        step(1'b1, DW'(i * 977), 1'b1);
        if (!in_req) lows++;
        acc += last_acc;
      end
      chk(lows == 0, "R7 in_req dropped at full rate", lows, 0);
      chk(acc == 30, "R7 one word per edge", acc, 30);
      drain();
    end

    // R2 R4 R5 R6: sweep every availability pattern against every ack pattern
    for (int ap = 1; ap < 16; ap++) begin
      for (int kp = 1; kp < 16; kp++) begin
        int sent, cyc;
        sent = 0;
        cyc  = 0;
        while ((sent < 10 || q_head != q_tail) && cyc < 300) begin
          logic av;
          logic [DW-1:0] d;
          av = (sent < 10) && ap[cyc % 4];
          d  = DW'(ap * 4099 + kp * 257 + sent * 7919);
          step(av, d, kp[cyc % 4]);
          sent += last_acc;
          cyc++;
        end
        chk(q_head == q_tail, "R6 sweep run complete", q_tail - q_head, 0);
      end
    end

    drain();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule